// File: doc/BRIEF.md
# R-R Interval Rhythm Monitor

This block judges heartbeat regularity in the time domain from a stream of digitised ECG samples. Each accepted sample goes through a reloadable 80-tap band-pass FIR filter, computed with a single multiply-accumulate unit, so one filtered value appears NTAPS clock cycles after the sample is accepted. The first difference of the filtered signal is compared against a programmable threshold to mark a beat. After a beat, a refractory span of filtered samples masks further beats. The distance between consecutive beats, counted in filtered samples, is collected into running sums.

A window-end strobe from the surrounding system, pulsed once per 10-second search window, closes the statistics. On that strobe the block reports the number of intervals and a dispersion figure equal to n squared times the variance of the intervals (the mean of the squared spacings minus the squared mean spacing, scaled by n squared so that no divider is needed). It raises an arrhythmia flag when that variance exceeds a programmable limit, or when too few beats were seen to judge. The system clock is expected to run far faster than the sample rate; samples must be at least NTAPS+1 cycles apart.

Top module: `rr_rhythm_monitor`

## Requirements
- R1: After reset, filt_valid, beat, res_valid, arr_flag and low_beats are 0, ival_count and disp_out are 0, all coefficients are 0, and the filter history holds zeros.
- R2: For each accepted sample x[n], filt_data = sum over k = 0..79 of c[k]*x[n-k] (signed, with x before the first sample equal to 0), presented with a one-cycle filt_valid pulse NTAPS cycles after the cycle in which smp_valid was sampled.
- R3: A cycle with coef_we high writes coef_val (signed) to tap coef_idx, where tap 0 multiplies the newest sample and tap 79 the oldest. Later outputs use the new value.
- R4: A filtered value y[n] is a beat when y[n]-y[n-1] > peak_thr (signed compare, y[-1] = 0) and no refractory span is active. beat pulses for one cycle, one cycle after the matching filt_valid.
- R5: After a beat, the next REFRACT (100) filtered samples cannot be beats. The sample 101 positions after the beat can be.
- R6: The interval recorded at a beat is the number of filtered samples from the previous beat to this one. It is recorded only if an earlier beat exists, and it may span a window boundary.
- R7: One cycle after win_end is high, res_valid pulses. ival_count gives the number n of intervals recorded since the previous window end, and disp_out = n*S2 - S1*S1, where S1 and S2 are the sum of intervals and the sum of squared intervals.
- R8: With at least 3 beats in the window, arr_flag = 1 exactly when disp_out > limit*n*n, that is when the variance exceeds limit.
- R9: With fewer than 3 beats in the window, arr_flag = 1 and low_beats = 1. Otherwise low_beats = 0.
- R10: Beat and interval accumulators are cleared at each window end, so a window reports only the beats and intervals that occurred in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Signed ECG sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_idx | input | IDX_W | Tap index to write |
| coef_val | input | COEF_W | Signed coefficient value |
| peak_thr | input | ACC_W+1 | Signed threshold on the first difference |
| limit | input | LIM_W | Variance limit |
| win_end | input | 1 | End-of-window strobe |
| filt_valid | output | 1 | Filtered value strobe |
| filt_data | output | ACC_W | Signed filtered value |
| beat | output | 1 | Beat detected pulse |
| res_valid | output | 1 | Window result strobe |
| arr_flag | output | 1 | Arrhythmia decision |
| low_beats | output | 1 | Too few beats in the window |
| ival_count | output | CNT_W | Intervals in the closed window |
| disp_out | output | DISP_W | n squared times interval variance |

## Verification
The hardest case to reach from the ports is the exact edge of the refractory span. A second rise must land precisely 100 and then 101 filtered samples after a beat, while the first-difference rule is still met. The stimulus loads a single-tap identity filter so that filtered values equal the input. It then places a spike 100 samples after a beat and a taller spike on the very next sample, so only the second difference clears the threshold. Intervals that cross a window boundary are reached by letting spike trains run across successive win_end pulses, and the expected dispersion is checked in each window.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef logic [63:0] wide_t;

  // n^2 * variance = n * sum(s^2) - (sum s)^2
  function automatic wide_t dispersion(input wide_t n, input wide_t s1, input wide_t s2);
    return n * s2 - s1 * s1;
  endfunction

  // variance > lim  <=>  n^2*variance > lim*n^2  (n > 0)
  function automatic logic over_limit(input wide_t disp, input wide_t n, input wide_t lim);
    return disp > lim * n * n;
  endfunction
endpackage

// File: rtl/rr_fir.sv
module rr_fir #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int NTAPS  = 80,
  localparam int IDX_W = $clog2(NTAPS),
  localparam int ACC_W = DATA_W + COEF_W + IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     coef_we,
  input  logic [IDX_W-1:0]         coef_idx,
  input  logic signed [COEF_W-1:0] coef_val,
  output logic                     out_valid,
  output logic signed [ACC_W-1:0]  out_data
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NTAPS - 1);

  logic signed [DATA_W-1:0] hist   [NTAPS];
  logic signed [COEF_W-1:0] coef_q [NTAPS];
  logic                     busy;
  logic [IDX_W-1:0]         idx;
  logic signed [ACC_W-1:0]  acc;
  logic signed [PROD_W-1:0] prod;
  logic                     take;

  assign take = in_valid && !busy;
  assign prod = coef_q[idx] * hist[idx];

  // sample history: tap 0 newest
  genvar g;
  generate
    for (g = 0; g < NTAPS; g++) begin : g_tap
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hist[g] <= '0;
        end else if (take) begin
          if (g == 0) hist[g] <= in_data;
          else        hist[g] <= hist[(g == 0) ? 0 : g - 1];
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          coef_q[g] <= '0;
        end else if (coef_we && (int'(coef_idx) == g)) begin
          coef_q[g] <= coef_val;
        end
      end
    end
  endgenerate

  // one multiply-accumulate per clock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (take) begin
        busy <= 1'b1;
        idx  <= '0;
        acc  <= '0;
      end else if (busy) begin
        if (idx == LAST) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= acc + ACC_W'(prod);
        end else begin
          acc <= acc + ACC_W'(prod);
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rr_peak.sv
module rr_peak #(
  parameter int VAL_W   = 23,
  parameter int REFRACT = 100,
  parameter int SP_W    = 16,
  localparam int RF_W   = $clog2(REFRACT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [VAL_W-1:0] in_data,
  input  logic signed [VAL_W:0]   thr,
  output logic                    peak,
  output logic                    ival_valid,
  output logic [SP_W-1:0]         ival
);
  localparam logic [SP_W-1:0] SP_MAX = '1;

  logic signed [VAL_W-1:0] prev;
  logic signed [VAL_W:0]   diff;
  logic [RF_W-1:0]         rcnt;
  logic [SP_W-1:0]         scnt;
  logic                    have_prev;
  logic                    fire;

  assign diff = (VAL_W + 1)'(in_data) - (VAL_W + 1)'(prev);
  assign fire = in_valid && (rcnt == '0) && (diff > thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev       <= '0;
      rcnt       <= '0;
      scnt       <= '0;
      have_prev  <= 1'b0;
      peak       <= 1'b0;
      ival_valid <= 1'b0;
      ival       <= '0;
    end else begin
      peak       <= 1'b0;
      ival_valid <= 1'b0;
      if (in_valid) begin
        prev <= in_data;
        if (rcnt != '0) rcnt <= rcnt - 1'b1;
        if (fire) begin
          peak      <= 1'b1;
          rcnt      <= RF_W'(REFRACT);
          have_prev <= 1'b1;
          scnt      <= '0;
          if (have_prev) begin
            ival_valid <= 1'b1;
            ival       <= (scnt == SP_MAX) ? SP_MAX : scnt + 1'b1;
          end
        end else if (scnt != SP_MAX) begin
          scnt <= scnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rr_stats.sv
module rr_stats #(
  parameter int SP_W      = 16,
  parameter int CNT_W     = 8,
  parameter int LIM_W     = 32,
  parameter int MIN_PEAKS = 3,
  localparam int S1_W     = SP_W + CNT_W,
  localparam int S2_W     = 2 * SP_W + CNT_W,
  localparam int DISP_W   = 2 * SP_W + 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              peak,
  input  logic              ival_valid,
  input  logic [SP_W-1:0]   ival,
  input  logic              win_end,
  input  logic [LIM_W-1:0]  limit,
  output logic              res_valid,
  output logic              flag,
  output logic              low,
  output logic [CNT_W-1:0]  ival_cnt,
  output logic [DISP_W-1:0] disp
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  pk_cnt;
  logic [CNT_W-1:0]  n_cnt;
  logic [S1_W-1:0]   s1;
  logic [S2_W-1:0]   s2;
  logic [2*SP_W-1:0] sq;
  rr_pkg::wide_t     disp_w;
  logic              low_w;
  logic              over_w;

  assign sq    = ival * ival;
  assign low_w = pk_cnt < CNT_W'(MIN_PEAKS);

  always_comb begin
    disp_w = rr_pkg::dispersion(64'(n_cnt), 64'(s1), 64'(s2));
    over_w = rr_pkg::over_limit(disp_w, 64'(n_cnt), 64'(limit));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pk_cnt    <= '0;
      n_cnt     <= '0;
      s1        <= '0;
      s2        <= '0;
      res_valid <= 1'b0;
      flag      <= 1'b0;
      low       <= 1'b0;
      ival_cnt  <= '0;
      disp      <= '0;
    end else begin
      res_valid <= 1'b0;
      if (win_end) begin
        res_valid <= 1'b1;
        low       <= low_w;
        flag      <= low_w || over_w;
        ival_cnt  <= n_cnt;
        disp      <= DISP_W'(disp_w);
        // an event on the closing cycle opens the next window
        pk_cnt    <= peak ? CNT_W'(1) : '0;
        n_cnt     <= ival_valid ? CNT_W'(1) : '0;
        s1        <= ival_valid ? S1_W'(ival) : '0;
        s2        <= ival_valid ? S2_W'(sq) : '0;
      end else begin
        if (peak && pk_cnt != CNT_MAX) pk_cnt <= pk_cnt + 1'b1;
        if (ival_valid && n_cnt != CNT_MAX) begin
          n_cnt <= n_cnt + 1'b1;
          s1    <= s1 + S1_W'(ival);
          s2    <= s2 + S2_W'(sq);
        end
      end
    end
  end
endmodule

// File: rtl/rr_rhythm_monitor.sv
module rr_rhythm_monitor #(
  parameter int DATA_W    = 8,
  parameter int COEF_W    = 8,
  parameter int NTAPS     = 80,
  parameter int REFRACT   = 100,
  parameter int SP_W      = 16,
  parameter int CNT_W     = 8,
  parameter int LIM_W     = 32,
  parameter int MIN_PEAKS = 3,
  localparam int IDX_W    = $clog2(NTAPS),
  localparam int ACC_W    = DATA_W + COEF_W + IDX_W,
  localparam int DISP_W   = 2 * SP_W + 2 * CNT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_data,
  input  logic                     coef_we,
  input  logic [IDX_W-1:0]         coef_idx,
  input  logic signed [COEF_W-1:0] coef_val,
  input  logic signed [ACC_W:0]    peak_thr,
  input  logic [LIM_W-1:0]         limit,
  input  logic                     win_end,
  output logic                     filt_valid,
  output logic signed [ACC_W-1:0]  filt_data,
  output logic                     beat,
  output logic                     res_valid,
  output logic                     arr_flag,
  output logic                     low_beats,
  output logic [CNT_W-1:0]         ival_count,
  output logic [DISP_W-1:0]        disp_out
);
  logic                    fv_w;
  logic signed [ACC_W-1:0] fd_w;
  logic                    peak_w;
  logic                    ivv_w;
  logic [SP_W-1:0]         iv_w;

  rr_fir #(.DATA_W(DATA_W), .COEF_W(COEF_W), .NTAPS(NTAPS)) u_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(smp_valid), .in_data(smp_data),
    .coef_we(coef_we), .coef_idx(coef_idx), .coef_val(coef_val),
    .out_valid(fv_w), .out_data(fd_w)
  );

  rr_peak #(.VAL_W(ACC_W), .REFRACT(REFRACT), .SP_W(SP_W)) u_peak (
    .clk(clk), .rst_n(rst_n), .in_valid(fv_w), .in_data(fd_w), .thr(peak_thr),
    .peak(peak_w), .ival_valid(ivv_w), .ival(iv_w)
  );

  rr_stats #(.SP_W(SP_W), .CNT_W(CNT_W), .LIM_W(LIM_W), .MIN_PEAKS(MIN_PEAKS)) u_stats (
    .clk(clk), .rst_n(rst_n), .peak(peak_w), .ival_valid(ivv_w), .ival(iv_w),
    .win_end(win_end), .limit(limit), .res_valid(res_valid), .flag(arr_flag),
    .low(low_beats), .ival_cnt(ival_count), .disp(disp_out)
  );

  assign filt_valid = fv_w;
  assign filt_data  = fd_w;
  assign beat       = peak_w;
endmodule

// File: rtl/rr_rhythm_chk.sv
module rr_rhythm_chk #(
  parameter int REFRACT = 100,
  localparam int GAP_W  = $clog2(REFRACT + 2)
) (
  input logic clk,
  input logic rst_n,
  input logic fv,
  input logic peak,
  input logic ivv,
  input logic win_end,
  input logic res_valid,
  input logic flag,
  input logic low
);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(REFRACT + 1);

  logic [GAP_W-1:0] gap;
  logic             armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap   <= '0;
      armed <= 1'b0;
    end else if (peak) begin
      gap   <= fv ? GAP_W'(1) : '0;
      armed <= 1'b1;
    end else if (fv && gap != GAP_MAX) begin
      gap <= gap + 1'b1;
    end
  end

  // R2
  single_filt_chk: assert property (@(posedge clk) disable iff (!rst_n) fv |=> !fv);
  // R4
  beat_follows_filt_chk: assert property (@(posedge clk) disable iff (!rst_n) peak |-> $past(fv));
  // R5
  refractory_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) peak |-> (!armed || gap == GAP_MAX));
  // R6
  ival_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n) ivv |-> peak);
  // R7
  result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $past(win_end));
  // R9
  low_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && low) |-> flag);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$past(win_end) |-> ($stable(flag) && $stable(low)));
endmodule

bind rr_rhythm_monitor rr_rhythm_chk #(.REFRACT(REFRACT)) u_chk (
  .clk(clk), .rst_n(rst_n), .fv(fv_w), .peak(peak_w), .ivv(ivv_w),
  .win_end(win_end), .res_valid(res_valid), .flag(arr_flag), .low(low_beats)
);

// File: tb/sim_rr_rhythm_monitor.sv
`timescale 1ns/1ps
module sim_rr_rhythm_monitor;
  localparam int NTAPS   = 80;
  localparam int REFRACT = 100;
  localparam int ACC_W   = 23;
  localparam int DISP_W  = 48;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    smp_valid = 1'b0;
  logic signed [7:0]       smp_data = '0;
  logic                    coef_we = 1'b0;
  logic [6:0]              coef_idx = '0;
  logic signed [7:0]       coef_val = '0;
  logic signed [ACC_W:0]   peak_thr = '0;
  logic [31:0]             limit = '0;
  logic                    win_end = 1'b0;
  logic                    filt_valid, beat, res_valid, arr_flag, low_beats;
  logic signed [ACC_W-1:0] filt_data;
  logic [7:0]              ival_count;
  logic [DISP_W-1:0]       disp_out;

  always #2.5 clk = ~clk;

  rr_rhythm_monitor u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .coef_we(coef_we), .coef_idx(coef_idx), .coef_val(coef_val),
    .peak_thr(peak_thr), .limit(limit), .win_end(win_end),
    .filt_valid(filt_valid), .filt_data(filt_data), .beat(beat),
    .res_valid(res_valid), .arr_flag(arr_flag), .low_beats(low_beats),
    .ival_count(ival_count), .disp_out(disp_out)
  );

  typedef struct { longint flag; longint low; longint cnt; longint disp; } win_t;

  int      n_checks = 0;
  int      n_err = 0;
  bit      done = 1'b0;
  longint  exp_filt[$];
  bit      exp_beat[$];
  win_t    exp_win[$];

  // reference model state
  int      m_coef[NTAPS];
  int      m_hist[NTAPS];
  longint  m_prev = 0;
  longint  m_thr = 0;
  int      m_rcnt = 0;
  int      m_scnt = 0;
  bit      m_have = 1'b0;
  int      m_beats = 0;
  longint  m_n = 0, m_s1 = 0, m_s2 = 0;

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_coef(input int k, input int v);
    @(negedge clk);
    coef_we = 1'b1; coef_idx = 7'(k); coef_val = 8'(v);
    m_coef[k] = v;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic set_thr(input longint t);
    peak_thr = (ACC_W + 1)'(t);
    m_thr = t;
  endtask

  // driver: predicts filtered value and beat, then drives the sample
  task automatic send(input int v);
    longint y, d;
    bit pk;
    for (int k = NTAPS - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
    m_hist[0] = v;
    y = 0;
    for (int k = 0; k < NTAPS; k++) y += longint'(m_coef[k]) * m_hist[k];
    exp_filt.push_back(y);
    d = y - m_prev;
    m_prev = y;
    pk = 1'b0;
    if (m_rcnt != 0) m_rcnt--;
    else if (d > m_thr) begin pk = 1'b1; m_rcnt = REFRACT; end
    if (pk) begin
      m_beats++;
      if (m_have) begin
        m_n++; m_s1 += m_scnt + 1; m_s2 += longint'(m_scnt + 1) * (m_scnt + 1);
      end
      m_have = 1'b1; m_scnt = 0;
    end else m_scnt++;
    exp_beat.push_back(pk);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 8'(v);
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (NTAPS + 3) @(negedge clk);
  endtask

  task automatic close_window(input longint lim);
    win_t w;
    limit = 32'(lim);
    w.low  = (m_beats < 3) ? 1 : 0;
    w.disp = m_n * m_s2 - m_s1 * m_s1;
    w.flag = (w.low == 1 || w.disp > lim * m_n * m_n) ? 1 : 0;
    w.cnt  = m_n;
    exp_win.push_back(w);
    m_beats = 0; m_n = 0; m_s1 = 0; m_s2 = 0;
    @(negedge clk);
    win_end = 1'b1;
    @(negedge clk);
    win_end = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: compares results as they appear
  bit pend_beat = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_beat) begin
        if (exp_beat.size() == 0) check("R4 beat queue", 1, 0);
        else check("R4/R5 beat", longint'(beat), longint'(exp_beat.pop_front()));
      end
      pend_beat = filt_valid;
      if (filt_valid) begin
        if (exp_filt.size() == 0) check("R2 filt queue", 1, 0);
        else check("R2/R3 filt_data", longint'(filt_data), exp_filt.pop_front());
      end
      if (res_valid) begin
        if (exp_win.size() == 0) check("R7 window queue", 1, 0);
        else begin
          win_t w;
          w = exp_win.pop_front();
          check("R6/R7/R10 ival_count", longint'(ival_count), w.cnt);
          check("R7 disp_out", longint'(disp_out), w.disp);
          check("R8/R9 arr_flag", longint'(arr_flag), w.flag);
          check("R9 low_beats", longint'(low_beats), w.low);
        end
      end
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NTAPS; k++) begin m_coef[k] = 0; m_hist[k] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 filt_valid", longint'(filt_valid), 0);
    check("R1 beat", longint'(beat), 0);
    check("R1 res_valid", longint'(res_valid), 0);
    check("R1 arr_flag", longint'(arr_flag), 0);
    check("R1 low_beats", longint'(low_beats), 0);
    check("R1 ival_count", longint'(ival_count), 0);
    check("R1 disp_out", longint'(disp_out), 0);

    // R3: identity filter (tap 0 = 1), R4 threshold 20
    load_coef(0, 1);
    set_thr(20);
    // window A: regular beats every 110 samples -> variance 0, R8 flag low
    for (int i = 0; i < 550; i++) send((i % 110 == 0) ? 50 : 0);
    close_window(10);
    // window B: irregular spacing, first interval spans the boundary (R6),
    // spike at 380 falls inside refractory span (R5)
    for (int i = 0; i < 650; i++)
      send((i == 20 || i == 150 || i == 340 || i == 380 || i == 445 || i == 600) ? 50 : 0);
    close_window(10);
    // window C: R5 boundary, spike 100 after beat is masked, 101 after counts
    for (int i = 0; i < 200; i++)
      send((i == 60 || i == 160) ? 50 : ((i == 161) ? 120 : 0));
    close_window(10);

    // R2/R3: full 80-tap filter with signed coefficients, no beats (R9)
    set_thr(4000000);
    for (int k = 0; k < NTAPS; k++) load_coef(k, ((k * 5) % 11) - 5);
    for (int i = 0; i < 90; i++) send(((i * 37) % 200) - 100);
    close_window(10);

    repeat (5) @(negedge clk);
    check("R2 leftover filt", longint'(exp_filt.size()), 0);
    check("R7 leftover windows", longint'(exp_win.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule